// File: doc/BRIEF.md
# Narrow-Bus Load/Store Unit

This block sits between a CPU pipeline and a 16-bit memory bus that uses Wishbone B4 pipelined signalling. The CPU side hands it one request at a time: a byte address, a transfer size of 8, 16, 32 or 64 bits, store data, and a load/store flag. The unit checks that the address is aligned to the transfer size. It then splits the transfer into 16-bit beats and drives them onto the bus as a back-to-back command stream. It also gathers the acknowledged read beats into a 64-bit result.

Two separate counters do the work. One counter moves through the command side. It advances only on cycles where the strobe is high and the stall input is low. The other counter moves through the response side and advances on each acknowledge. Because of this split, the unit can issue later beats before earlier beats have been acknowledged. The bus cycle signal stays up until the last expected acknowledge has arrived. A one-cycle done pulse then delivers the load result.

Top module: `lsu_narrow`

## Requirements
- R1: After reset, and whenever the unit is idle, `ready_o` is high. A request is taken only on a clock edge where `req_valid_i` and `ready_o` are both high. From the cycle after an aligned request is taken, `ready_o` stays low until the cycle in which `done_o` pulses. Requests presented while busy are ignored.
- R2: The size code on `req_size_i` sets the number of bus beats: 0 (8-bit) gives 1 beat, 1 (16-bit) gives 1, 2 (32-bit) gives 2, and 3 (64-bit) gives 4.
- R3: Beat k carries byte address base + 2k, so beats go out in ascending order. An 8-bit access keeps its full byte address, including bit 0. The first beat is on the bus in the cycle after acceptance.
- R4: A beat is consumed only on a clock edge where `wb_stb_o` is high and `wb_stall_i` is low. While stalled, the address, data and byte select of the beat are held.
- R5: With no stall, all beats of a request go out on consecutive cycles, without waiting for acknowledges.
- R6: For an 8-bit access, `wb_sel_o` is 2'b01 at an even address and 2'b10 at an odd address, and the store byte appears on both lanes. For wider accesses, `wb_sel_o` is 2'b11 and beat k carries store data bits [16k+15:16k].
- R7: On a load, the k-th acknowledged beat fills result bits [16k+15:16k], and bits above the transfer size are zero. For an 8-bit load, the result is the byte from the lane that address bit 0 selects, zero-extended.
- R8: If the address is not a multiple of the transfer size, the unit issues no bus beat. It raises `misalign_o` for exactly one cycle, in the cycle after the request, and `ready_o` stays high.
- R9: `wb_cyc_o` rises with the first beat, stays high until the final expected acknowledge, and is low in the cycle after it.
- R10: `done_o` pulses for exactly one cycle, in the cycle after the final acknowledge. A load result on `rdata_o` is valid with that pulse, and for a store `rdata_o` is zero. Acknowledges that arrive while idle do not cause a pulse.
- R11: `wb_we_o` is high on every beat of a store and low on every beat of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 64 | Store data, right-aligned |
| ready_o | output | 1 | Idle; a request can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 64 | Assembled load data |
| misalign_o | output | 1 | One-cycle misalignment error pulse |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Beat strobe |
| wb_we_o | output | 1 | Beat write enable |
| wb_adr_o | output | AW | Beat byte address |
| wb_dat_o | output | 16 | Beat write data |
| wb_sel_o | output | 2 | Byte-lane select |
| wb_stall_i | input | 1 | Slave cannot take a beat |
| wb_ack_i | input | 1 | Beat acknowledge |
| wb_dat_i | input | 16 | Beat read data |

## Verification
The assertions check the cycle-level bus rules on every cycle. Strobe never appears outside a bus cycle. A stalled beat holds its address, data and lane select. A one-hot lane select always matches address bit 0. A fall of the bus cycle always coincides with a one-cycle done pulse. The misalignment pulse never overlaps bus activity. Only the bench scenarios can show the content of the beats: their number per size, their address sequence and store slicing, the little-endian placement of read beats and the zero-extension of byte loads. The scenarios also show that requests and acknowledges arriving while idle or busy have no effect, and that beats stream without gaps once stalls are removed.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int BUS_W     = 16;
  localparam int DATA_W    = 64;
  localparam int SEL_W     = BUS_W / 8;
  localparam int LANE_W    = $clog2(SEL_W);
  localparam int MAX_BEATS = DATA_W / BUS_W;
  localparam int IDX_W     = $clog2(MAX_BEATS);
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;
endpackage

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_pkg::*;
(
  input  size_e            size_i,
  input  logic [2:0]       addr_lo_i,
  output logic             misaligned_o,
  output logic [CNT_W-1:0] nbeats_o
);
  always_comb begin
    case (size_i)
      SZ_B: begin misaligned_o = 1'b0;            nbeats_o = CNT_W'(1); end
      SZ_H: begin misaligned_o = addr_lo_i[0];    nbeats_o = CNT_W'(1); end
      SZ_W: begin misaligned_o = |addr_lo_i[1:0]; nbeats_o = CNT_W'(2); end
      default: begin misaligned_o = |addr_lo_i;   nbeats_o = CNT_W'(MAX_BEATS); end
    endcase
  end
endmodule

// File: rtl/lsu_cmd.sv
module lsu_cmd
  import lsu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              we_i,
  input  size_e             size_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  nbeats_i,
  input  logic              stall_i,
  output logic              stb_o,
  output logic              we_o,
  output logic [AW-1:0]     adr_o,
  output logic [BUS_W-1:0]  dat_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic [AW-1:0]     base_q;
  logic [DATA_W-1:0] wdata_q;
  size_e             size_q;
  logic              we_q;
  logic [CNT_W-1:0]  nb_q, icnt_q;
  logic [BUS_W-1:0]  slice [MAX_BEATS];

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slice
    assign slice[g] = wdata_q[g*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      wdata_q <= '0;
      size_q  <= SZ_B;
      we_q    <= 1'b0;
      nb_q    <= '0;
      icnt_q  <= '0;
    end else if (start_i) begin
      base_q  <= addr_i;
      wdata_q <= wdata_i;
      size_q  <= size_i;
      we_q    <= we_i;
      nb_q    <= nbeats_i;
      icnt_q  <= '0;
    end else if (stb_o && !stall_i) begin
      icnt_q  <= icnt_q + CNT_W'(1);
    end
  end

  assign stb_o = busy_i && (icnt_q < nb_q);
  assign we_o  = we_q;
  assign adr_o = base_q + AW'({icnt_q, 1'b0});
  assign dat_o = (size_q == SZ_B) ? {SEL_W{wdata_q[7:0]}} : slice[icnt_q[IDX_W-1:0]];
  assign sel_o = (size_q == SZ_B) ? (SEL_W'(1) << base_q[LANE_W-1:0]) : '1;
endmodule

// File: rtl/lsu_rsp.sv
module lsu_rsp
  import lsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              we_i,
  input  size_e             size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [CNT_W-1:0]  nbeats_i,
  input  logic              ack_i,
  input  logic [BUS_W-1:0]  dat_i,
  output logic              last_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0]  rcnt_q, nb_q;
  logic              we_q;
  size_e             size_q;
  logic [LANE_W-1:0] lane_q;
  logic              hit;
  logic [7:0]        byte_pick;

  assign hit       = busy_i && ack_i;
  assign last_o    = hit && (rcnt_q == nb_q - CNT_W'(1));
  assign byte_pick = dat_i[{lane_q, 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q <= '0;
      nb_q   <= '0;
      we_q   <= 1'b0;
      size_q <= SZ_B;
      lane_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (start_i) begin
        rcnt_q <= '0;
        nb_q   <= nbeats_i;
        we_q   <= we_i;
        size_q <= size_i;
        lane_q <= lane_i;
      end else if (hit) begin
        rcnt_q <= rcnt_q + CNT_W'(1);
      end
    end
  end

  // one result lane per beat position
  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_lane
    logic [BUS_W-1:0] acc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        acc_q <= '0;
      else if (start_i)
        acc_q <= '0;
      else if (hit && !we_q && rcnt_q == CNT_W'(g))
        acc_q <= (size_q == SZ_B) ? BUS_W'(byte_pick) : dat_i;
    end
    assign rdata_o[g*BUS_W +: BUS_W] = acc_q;
  end
endmodule

// File: rtl/lsu_narrow.sv
module lsu_narrow
  import lsu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              misalign_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [AW-1:0]     wb_adr_o,
  output logic [BUS_W-1:0]  wb_dat_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  input  logic              wb_stall_i,
  input  logic              wb_ack_i,
  input  logic [BUS_W-1:0]  wb_dat_i
);
  size_e            size;
  logic             mis, try_q, start, last, busy_q, mis_q;
  logic [CNT_W-1:0] nbeats;

  assign size  = size_e'(req_size_i);
  assign try_q = req_valid_i && !busy_q;
  assign start = try_q && !mis;

  lsu_align u_align (
    .size_i      (size),
    .addr_lo_i   (req_addr_i[2:0]),
    .misaligned_o(mis),
    .nbeats_o    (nbeats)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      mis_q <= try_q && mis;
      if (start)     busy_q <= 1'b1;
      else if (last) busy_q <= 1'b0;
    end
  end

  lsu_cmd #(.AW(AW)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_i  (busy_q),
    .we_i    (req_we_i),
    .size_i  (size),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .nbeats_i(nbeats),
    .stall_i (wb_stall_i),
    .stb_o   (wb_stb_o),
    .we_o    (wb_we_o),
    .adr_o   (wb_adr_o),
    .dat_o   (wb_dat_o),
    .sel_o   (wb_sel_o)
  );

  lsu_rsp u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_i  (busy_q),
    .we_i    (req_we_i),
    .size_i  (size),
    .lane_i  (req_addr_i[LANE_W-1:0]),
    .nbeats_i(nbeats),
    .ack_i   (wb_ack_i),
    .dat_i   (wb_dat_i),
    .last_o  (last),
    .done_o  (done_o),
    .rdata_o (rdata_o)
  );

  assign ready_o    = !busy_q;
  assign wb_cyc_o   = busy_q;
  assign misalign_o = mis_q;
endmodule

// File: rtl/lsu_narrow_chk.sv
module lsu_narrow_chk
  import lsu_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             ready_o,
  input logic             done_o,
  input logic             misalign_o,
  input logic             wb_cyc_o,
  input logic             wb_stb_o,
  input logic             wb_stall_i,
  input logic [AW-1:0]    wb_adr_o,
  input logic [BUS_W-1:0] wb_dat_o,
  input logic [SEL_W-1:0] wb_sel_o
);
  p_stb_in_cyc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o);

  p_cyc_fall_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wb_cyc_o) |-> done_o);

  p_cyc_rise_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_cyc_o) |-> $past(req_valid_i && ready_o));

  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && wb_stall_i) |=> (wb_stb_o && $stable(wb_adr_o) &&
                                  $stable(wb_dat_o) && $stable(wb_sel_o)));

  p_lane_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && wb_sel_o != '1) |-> ($onehot0(wb_sel_o) && wb_sel_o[wb_adr_o[LANE_W-1:0]]));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && !wb_cyc_o));

  p_mis_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!wb_cyc_o && !done_o && ready_o));

  p_mis_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !misalign_o || $past(req_valid_i));
endmodule

bind lsu_narrow lsu_narrow_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_lsu_narrow.sv
module tb_lsu_narrow;
  localparam int AW = 32;
  localparam int NV = 13;
  localparam int LOGN = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        ready_o, done_o, misalign_o, wb_cyc_o, wb_stb_o, wb_we_o;
  logic [63:0] rdata_o;
  logic [31:0] wb_adr_o;
  logic [15:0] wb_dat_o, wb_dat_i;
  logic [1:0]  wb_sel_o;
  logic        wb_stall_i, wb_ack_i;

  lsu_narrow #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o), .misalign_o(misalign_o),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o),
    .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o), .wb_stall_i(wb_stall_i),
    .wb_ack_i(wb_ack_i), .wb_dat_i(wb_dat_i)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // slave model: stall pattern, two-cycle ack latency
  logic        stall_en = 1'b0, force_ack = 1'b0, stall_r = 1'b0;
  logic        p0 = 1'b0, p1 = 1'b0;
  logic [15:0] d0 = '0, d1 = '0;
  int          free = 0, cyc_n = 0, beat_n = 0;
  logic [31:0] b_adr [LOGN];
  logic [15:0] b_dat [LOGN];
  logic [1:0]  b_sel [LOGN];
  logic        b_we  [LOGN];
  int          b_cyc [LOGN];

  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {~a[7:0], a[8:1] ^ 8'h3C};
  endfunction

  assign wb_stall_i = stall_r;
  assign wb_ack_i   = p1 | force_ack;
  assign wb_dat_i   = d1;

  always @(posedge clk) begin
    free    <= free + 1;
    cyc_n   <= cyc_n + 1;
    stall_r <= stall_en && (free % 3 == 1);
    p0      <= wb_stb_o && !wb_stall_i;
    d0      <= rd16({wb_adr_o[31:1], 1'b0});
    p1      <= p0;
    d1      <= d0;
    if (wb_stb_o && !wb_stall_i && beat_n < LOGN) begin
      b_adr[beat_n] <= wb_adr_o;
      b_dat[beat_n] <= wb_dat_o;
      b_sel[beat_n] <= wb_sel_o;
      b_we[beat_n]  <= wb_we_o;
      b_cyc[beat_n] <= cyc_n;
      beat_n        <= beat_n + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // {stall, we, size, addr[15:0], wdata}
  localparam logic [83:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd3, 16'h0100, 64'h0},
    {1'b1, 1'b0, 2'd3, 16'h0208, 64'h0},
    {1'b0, 1'b1, 2'd3, 16'h0300, 64'h1122334455667788},
    {1'b1, 1'b1, 2'd2, 16'h0404, 64'h00000000DEADBEEF},
    {1'b0, 1'b0, 2'd2, 16'h0510, 64'h0},
    {1'b0, 1'b0, 2'd1, 16'h0602, 64'h0},
    {1'b0, 1'b1, 2'd1, 16'h0706, 64'h000000000000A5C3},
    {1'b0, 1'b0, 2'd0, 16'h0801, 64'h0},
    {1'b0, 1'b0, 2'd0, 16'h0900, 64'h0},
    {1'b1, 1'b1, 2'd0, 16'h0A03, 64'h000000000000005E},
    {1'b0, 1'b0, 2'd3, 16'h0B04, 64'h0},
    {1'b1, 1'b1, 2'd2, 16'h0C02, 64'h0},
    {1'b0, 1'b0, 2'd1, 16'h0D01, 64'h0}
  };

  int last_b0 = 0;

  task automatic run_vec(input logic st, input logic we, input logic [1:0] sz,
                         input logic [31:0] ad, input logic [63:0] wd);
    int nb, b0;
    bit mis, got_done, rdy_ok, cyc_ok;
    logic [63:0] exp_rd;
    logic [15:0] w;
    nb  = (sz == 2'd3) ? 4 : (sz == 2'd2) ? 2 : 1;
    mis = (ad & ((32'd1 << sz) - 32'd1)) != 0;
    exp_rd = '0;
    if (!we) begin
      if (sz == 2'd0) begin
        w = rd16({ad[31:1], 1'b0});
        exp_rd = {56'h0, ad[0] ? w[15:8] : w[7:0]};
      end else begin
        for (int k = 0; k < nb; k++) exp_rd[16*k +: 16] = rd16(ad + 32'(2*k));
      end
    end
    @(negedge clk);
    stall_en = st;
    b0 = beat_n;
    last_b0 = b0;
    req_we = we; req_size = sz; req_addr = ad; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis) begin
      chk(misalign_o == 1'b1, "R8 error pulse", 64'(misalign_o), 64'h1);
      chk(ready_o == 1'b1, "R8 ready stays high", 64'(ready_o), 64'h1);
      @(negedge clk);
      chk(misalign_o == 1'b0, "R8 pulse one cycle", 64'(misalign_o), 64'h0);
      got_done = 0;
      for (int i = 0; i < 6; i++) begin
        if (done_o || wb_cyc_o) got_done = 1;
        @(negedge clk);
      end
      chk(beat_n == b0 && !got_done, "R8 no bus activity", 64'(beat_n - b0), 64'h0);
      return;
    end
    chk(misalign_o == 1'b0, "R8 aligned no error", 64'(misalign_o), 64'h0);
    got_done = 0; rdy_ok = 1; cyc_ok = 1;
    for (int i = 0; i < 80; i++) begin
      if (done_o) begin got_done = 1; break; end
      if (ready_o) rdy_ok = 0;
      if (!wb_cyc_o) cyc_ok = 0;
      @(negedge clk);
    end
    chk(got_done, "R10 done pulse seen", 64'(got_done), 64'h1);
    chk(rdy_ok, "R1 ready low while busy", 64'(rdy_ok), 64'h1);
    chk(cyc_ok, "R9 cyc high until last ack", 64'(cyc_ok), 64'h1);
    chk(!wb_cyc_o, "R9 cyc low after last ack", 64'(wb_cyc_o), 64'h0);
    chk(ready_o, "R1 ready back with done", 64'(ready_o), 64'h1);
    if (we) chk(rdata_o == 64'h0, "R10 store result zero", rdata_o, 64'h0);
    else    chk(rdata_o == exp_rd, "R7 load assembly", rdata_o, exp_rd);
    chk(beat_n - b0 == nb, "R2 beat count", 64'(beat_n - b0), 64'(nb));
    for (int k = 0; k < nb && k < beat_n - b0; k++) begin
      logic [1:0]  es;
      logic [15:0] ed;
      es = (sz == 2'd0) ? (ad[0] ? 2'b10 : 2'b01) : 2'b11;
      ed = (sz == 2'd0) ? {2{wd[7:0]}} : wd[16*k +: 16];
      chk(b_adr[b0+k] == ad + 32'(2*k), st ? "R4 address under stall" : "R3 beat address",
          64'(b_adr[b0+k]), 64'(ad + 32'(2*k)));
      chk(b_sel[b0+k] == es, "R6 byte select", 64'(b_sel[b0+k]), 64'(es));
      if (we) chk(b_dat[b0+k] == ed, "R6 store lane data", 64'(b_dat[b0+k]), 64'(ed));
      chk(b_we[b0+k] == we, "R11 write enable", 64'(b_we[b0+k]), 64'(we));
    end
    @(negedge clk);
    chk(!done_o, "R10 done one cycle", 64'(done_o), 64'h0);
  endtask

  initial begin
    int b_hold;
    bit bad;
    // reset state
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1, "R1 reset ready", 64'(ready_o), 64'h1);
    chk(!wb_cyc_o && !wb_stb_o, "R9 reset bus idle", {62'h0, wb_cyc_o, wb_stb_o}, 64'h0);
    chk(!done_o && !misalign_o, "R10 reset no pulses", {62'h0, done_o, misalign_o}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][83], VEC[v][82], VEC[v][81:80], {16'h0, VEC[v][79:64]}, VEC[v][63:0]);

    // R5: unstalled 64-bit load streams on consecutive cycles
    run_vec(1'b0, 1'b0, 2'd3, 32'h0000_4000, 64'h0);
    for (int k = 1; k < 4; k++)
      chk(b_cyc[last_b0+k] - b_cyc[last_b0] == k, "R5 back-to-back beats",
          64'(b_cyc[last_b0+k] - b_cyc[last_b0]), 64'(k));

    // R1: request held while busy is ignored
    @(negedge clk);
    stall_en = 1'b1;
    b_hold = beat_n;
    req_we = 1'b0; req_size = 2'd2; req_addr = 32'h0000_1000; req_valid = 1'b1;
    @(negedge clk);
    req_size = 2'd3; req_addr = 32'h0000_2000;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60 && !done_o; i++) @(negedge clk);
    chk(rdata_o == {32'h0, rd16(32'h1002), rd16(32'h1000)}, "R1 busy request ignored",
        rdata_o, {32'h0, rd16(32'h1002), rd16(32'h1000)});
    repeat (5) @(negedge clk);
    chk(beat_n - b_hold == 2, "R1 no beats from ignored request", 64'(beat_n - b_hold), 64'h2);
    chk(b_adr[b_hold+1] == 32'h1002, "R3 second beat address", 64'(b_adr[b_hold+1]), 64'h1002);

    // R10: acknowledges while idle are ignored
    stall_en = 1'b0;
    force_ack = 1'b1;
    bad = 0;
    repeat (3) begin
      @(negedge clk);
      if (done_o || !ready_o) bad = 1;
    end
    force_ack = 1'b0;
    @(negedge clk);
    if (done_o || !ready_o) bad = 1;
    chk(!bad, "R10 idle ack ignored", 64'(bad), 64'h0);
    run_vec(1'b0, 1'b0, 2'd1, 32'h0000_3000, 64'h0);
    run_vec(1'b1, 1'b0, 2'd0, 32'h0000_3005, 64'h0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule